// File: doc/BRIEF.md
# I2C Two-Stage Timing Generator

This block derives every timing reference an I2C controller needs from one system clock. A power-of-two prescaler, set by a 3-bit exponent, emits a one-cycle sampling strobe. A second counter counts those strobes against a 4-bit scalar and toggles the master-mode SCL level. The sampling rate and the SCL rate are set separately, so the bus can be sampled far more often than the controller drives its own clock. That margin lets a multi-master bus see every START and STOP. Bus sampling needs at least ten samples per bit of the fastest master: 1 MHz for 100 kbit/s traffic and 4 MHz for 400 kbit/s.

The same strobe clocks a condition detector. SDA and SCL are first passed through a synchronizer. On each strobe the detector samples both lines and pulses a flag when SDA moves while SCL is high. Writing the control word restarts both counters. Dropping the enable parks all timing with SCL released high.

Top module: `i2c_clk_timebase`

## Requirements
- R1: The control word uses bits [2:0] as the exponent N and bits [6:3] as the scalar M. It loads on the rising edge where `cfg_wr` is high and resets to zero, which gives N=0 and M=0.
- R2: While enabled, `sample_stb` is a one-cycle pulse repeating every 2^N clocks. The first strobe follows the 2^N-th rising edge after counting starts. With N=0 it stays high on every cycle.
- R3: `scl_master` starts high and inverts after every 5·(M+1) strobes. This gives a 50% duty cycle and a period of 10·(M+1)·2^N clocks. The first fall follows the 5·(M+1)·2^N-th edge after counting starts.
- R4: `scl_edge` is high for exactly the cycles in which a strobe completes a half period. `scl_master` changes on the next rising edge.
- R5: For a fixed N, the strobe pattern is identical for every value of M.
- R6: A control write clears both counters at that edge. In the next cycle `sample_stb` and `scl_edge` are low and `scl_master` is high. Counting restarts from the following edge with the new values.
- R7: With `enable` low, there are no strobes, no SCL edges and no START or STOP flags, and `scl_master` stays high. After re-enabling, timing restarts from zero.
- R8: `start_det` pulses for one cycle when the sampled SDA goes from 1 to 0 while the sampled SCL is 1.
- R9: `stop_det` pulses for one cycle when the sampled SDA goes from 0 to 1 while the sampled SCL is 1.
- R10: SDA movement while the sampled SCL is 0 raises no flag. The lines are examined only on strobes, after a two-flop synchronizer.
- R11: During reset `sample_stb`, `scl_edge`, `start_det` and `stop_det` are low and `scl_master` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Runs the dividers when high |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 7 | Control word: [6:3] scalar M, [2:0] exponent N |
| sda_in | input | 1 | Bus data line, asynchronous |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sample_stb | output | 1 | One-cycle bus sampling strobe |
| scl_master | output | 1 | Master-mode SCL level |
| scl_edge | output | 1 | Pulse one cycle ahead of each SCL change |
| start_det | output | 1 | START condition pulse |
| stop_det | output | 1 | STOP condition pulse |

## Verification
The dividers are swept across every scalar for exponents 0 to 3, and a few large-exponent settings are added. In each setting, the strobe, the SCL level and the edge pulse are predicted for every cycle from 2^N and 5·(M+1). That sweep separates an off-by-one in either stage, swapped fields and a wrong duty cycle. It also catches any leak of M into the sampling rate. Writes made while counting run mid-stream and must restart the count exactly. The detector is fed SDA falls and rises with SCL high and with SCL low, at a fast and a slow strobe and while disabled. This separates real conditions from data changes and from ignored input.

// File: rtl/i2ctb_pkg.sv
// Shared widths and the control word layout for the I2C timing generator.
package i2ctb_pkg;
    localparam int EXP_W  = 3;               // exponent field width
    localparam int SCAL_W = 4;               // scalar field width
    localparam int CFG_W  = EXP_W + SCAL_W;  // whole control word

    // Control word: scalar in the upper bits, exponent in the low bits.
    typedef struct packed {
        logic [SCAL_W-1:0] scal;
        logic [EXP_W-1:0]  expo;
    } cfg_t;
endpackage

// File: rtl/i2ctb_prescaler.sv
// Exponent stage: divides the system clock by 2^expo and emits a registered
// one-cycle strobe. Assumes clr is high for the cycle of a control write.
module i2ctb_prescaler
    import i2ctb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic [EXP_W-1:0] expo,
    output logic             stb
);
    localparam int CNT_W = (1 << EXP_W) - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic             at_lim;

    // Terminal count 2^expo - 1 as a mask of expo low ones.
    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            lim[i] = (i < int'(expo));
        end
    end

    assign at_lim = (cnt == lim);

    // Free-running counter with registered strobe; cleared when idle or on write.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || clr) begin
            cnt <= '0;
            stb <= 1'b0;
        end else begin
            stb <= at_lim;
            cnt <= at_lim ? '0 : cnt + 1'b1;
        end
    end

    AST_STB_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!en || clr) |=> !stb) else $error("strobe while idle");   // R7
    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && expo != '0) |=> !stb) else $error("strobe too wide"); // R2
endmodule

// File: rtl/i2ctb_scaler.sv
// Scalar stage: counts prescaler strobes and inverts the SCL level after
// HALF_MULT*(scal+1) of them. Assumes stb is one cycle wide.
module i2ctb_scaler
    import i2ctb_pkg::*;
#(
    parameter int HALF_MULT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              clr,
    input  logic              stb,
    input  logic [SCAL_W-1:0] scal,
    output logic              scl,
    output logic              scl_edge
);
    localparam int MAX_HALF = HALF_MULT * (1 << SCAL_W);
    localparam int CNT_W    = $clog2(MAX_HALF);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    // Strobes per half period, minus one.
    assign lim = CNT_W'(HALF_MULT * (int'(scal) + 1) - 1);

    // Edge marks the strobe that completes a half period.
    assign scl_edge = en && !clr && stb && (cnt == lim);

    // Half-period counter and SCL level; released high when idle or on write.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || clr) begin
            cnt <= '0;
            scl <= 1'b1;
        end else if (stb) begin
            if (cnt == lim) begin
                cnt <= '0;
                scl <= ~scl;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_EDGE_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        scl_edge |=> (scl != $past(scl))) else $error("edge without toggle"); // R4
    AST_SCL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && !scl_edge) |=> $stable(scl)) else $error("stray toggle"); // R3
    AST_SCL_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> scl) else $error("scl low while idle");                         // R7
endmodule

// File: rtl/i2ctb_cond_detect.sv
// Synchronizes SDA/SCL, samples them on each strobe and pulses START/STOP.
// Assumes SYNC_STAGES >= 1 and an idle bus (both lines high) after reset.
module i2ctb_cond_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic sda_in,
    input  logic scl_in,
    output logic start_det,
    output logic stop_det
);
    logic [1:0] sh [SYNC_STAGES];   // [1]=sda, [0]=scl per stage
    logic       sda_s, scl_s;
    logic       sda_q;

    assign sda_s = sh[SYNC_STAGES-1][1];
    assign scl_s = sh[SYNC_STAGES-1][0];

    // Synchronizer chain for both bus lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) sh[i] <= 2'b11;
        end else begin
            sh[0] <= {sda_in, scl_in};
            for (int i = 1; i < SYNC_STAGES; i++) sh[i] <= sh[i-1];
        end
    end

    // Strobe-time sampling of SDA and condition flagging.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_q     <= 1'b1;
            start_det <= 1'b0;
            stop_det  <= 1'b0;
        end else begin
            start_det <= stb && sda_q && !sda_s && scl_s;
            stop_det  <= stb && !sda_q && sda_s && scl_s;
            if (stb) sda_q <= sda_s;
        end
    end

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !start_det) else $error("wide start");     // R8
    AST_STOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !stop_det) else $error("wide stop");        // R9
    AST_FLAG_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det || stop_det) |-> $past(stb)) else $error("flag off strobe"); // R10
endmodule

// File: rtl/i2c_clk_timebase.sv
// Top: control word register, exponent prescaler feeding the scalar SCL
// stage, and the START/STOP detector clocked by the same strobe.
// Assumes cfg_wr is synchronous to clk; a write restarts all counting.
module i2c_clk_timebase
    import i2ctb_pkg::*;
#(
    parameter int HALF_MULT   = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             sda_in,
    input  logic             scl_in,
    output logic             sample_stb,
    output logic             scl_master,
    output logic             scl_edge,
    output logic             start_det,
    output logic             stop_det
);
    cfg_t cfg_q;

    // Control word register.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_wr) cfg_q <= cfg_t'(cfg_wdata);
    end

    i2ctb_prescaler u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (enable),
        .clr   (cfg_wr),
        .expo  (cfg_q.expo),
        .stb   (sample_stb)
    );

    i2ctb_scaler #(.HALF_MULT(HALF_MULT)) u_scl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (enable),
        .clr      (cfg_wr),
        .stb      (sample_stb),
        .scal     (cfg_q.scal),
        .scl      (scl_master),
        .scl_edge (scl_edge)
    );

    i2ctb_cond_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (sample_stb),
        .sda_in    (sda_in),
        .scl_in    (scl_in),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (cfg_q == $past(cfg_wdata))) else $error("cfg not loaded"); // R1
    AST_WR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (!sample_stb && scl_master)) else $error("no restart");     // R6
endmodule

// File: tb/i2c_clk_timebase_tb.sv
module i2c_clk_timebase_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [6:0] cfg_wdata = '0;
    logic       sda_in = 1'b1;
    logic       scl_in = 1'b1;
    logic       sample_stb, scl_master, scl_edge, start_det, stop_det;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_clk_timebase u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .sda_in(sda_in), .scl_in(scl_in),
        .sample_stb(sample_stb), .scl_master(scl_master), .scl_edge(scl_edge),
        .start_det(start_det), .stop_det(stop_det)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Program M/N and check strobe, SCL level and edge pulse on every cycle.
    task automatic run_cfg(input int m, input int n, input bit mid);
        int per, half, base, win;
        int e_stb, e_scl, e_edg;
        per = 1 << n;
        half = 5 * (m + 1) * per;
        e_stb = 0; e_scl = 0; e_edg = 0;
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = 7'((m << 3) | n);
        if (!mid) begin
            enable = 1'b0;
            @(negedge clk);
            cfg_wr = 1'b0;
            enable = 1'b1;
            base = 0;
        end else begin
            base = 1;
        end
        win = base + 2 * half + 3;
        for (int j = 0; j < win; j++) begin
            bit xs, xc, xe;
            int r;
            @(negedge clk);
            if (mid && j == 0) begin
                // R6: restart state right after the write edge
                chk(!sample_stb && scl_master && !scl_edge, "R6 restart state",
                    {sample_stb, scl_master, scl_edge}, 3'b010);
                cfg_wr = 1'b0;
            end
            r = j - base;
            xs = (r >= 0) && ((r + 1) % per == 0);
            xc = (r < 0) ? 1'b1 : ((r / half) % 2 == 0);
            xe = (r >= 0) && ((r + 1) % half == 0);
            if (sample_stb !== xs) e_stb++;
            if (scl_master !== xc) e_scl++;
            if (scl_edge !== xe) e_edg++;
        end
        chk(e_stb == 0, $sformatf("R2/R5 strobe pattern M=%0d N=%0d", m, n), e_stb, 0);
        chk(e_scl == 0, $sformatf("R3 scl level M=%0d N=%0d", m, n), e_scl, 0);
        chk(e_edg == 0, $sformatf("R4 scl_edge M=%0d N=%0d", m, n), e_edg, 0);
    endtask

    // Count flag pulses and flag-high cycles over a window.
    task automatic watch(input int cyc, output int rs, output int hs, output int rp, output int hp);
        bit ps, pp;
        rs = 0; hs = 0; rp = 0; hp = 0; ps = 0; pp = 0;
        for (int j = 0; j < cyc; j++) begin
            @(negedge clk);
            if (start_det) hs++;
            if (start_det && !ps) rs++;
            if (stop_det) hp++;
            if (stop_det && !pp) rp++;
            ps = start_det; pp = stop_det;
        end
    endtask

    task automatic set_cfg(input int m, input int n);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = 7'((m << 3) | n);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog all-R actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int rs, hs, rp, hp, e;
        // R11: reset state
        enable = 1'b1;
        repeat (4) @(negedge clk);
        chk(!sample_stb && scl_master && !scl_edge && !start_det && !stop_det,
            "R11 reset outputs", {sample_stb, scl_master, scl_edge, start_det, stop_det}, 5'b01000);
        enable = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        enable = 1'b1;
        // R1: reset control word acts as M=0, N=0
        e = 0;
        for (int j = 0; j < 12; j++) begin
            @(negedge clk);
            if (sample_stb !== 1'b1) e++;
            if (scl_master !== (((j / 5) % 2) == 0)) e++;
        end
        chk(e == 0, "R1 reset cfg M=0 N=0", e, 0);

        // Divider sweep
        for (int n = 0; n < 4; n++)
            for (int m = 0; m < 16; m++)
                run_cfg(m, n, 1'b0);
        run_cfg(3, 5, 1'b0);
        run_cfg(0, 7, 1'b0);
        run_cfg(1, 6, 1'b0);
        // R6: writes while running
        run_cfg(2, 1, 1'b1);
        run_cfg(0, 0, 1'b1);
        run_cfg(7, 2, 1'b1);

        // R7: disabled
        @(negedge clk);
        enable = 1'b0;
        e = 0;
        for (int j = 0; j < 200; j++) begin
            @(negedge clk);
            sda_in = j[2];
            if (sample_stb || scl_edge || !scl_master || start_det || stop_det) e++;
        end
        chk(e == 0, "R7 idle outputs and flags", e, 0);
        sda_in = 1'b1;
        repeat (5) @(negedge clk);
        run_cfg(1, 2, 1'b0);

        // Condition detection at a strobe on every cycle
        set_cfg(0, 0);
        @(negedge clk);
        enable = 1'b1;
        watch(10, rs, hs, rp, hp);
        sda_in = 1'b0;
        watch(12, rs, hs, rp, hp);
        chk(rs == 1 && hs == 1 && rp == 0, "R8 start one pulse", rs * 10 + hs, 11);
        sda_in = 1'b1;
        watch(12, rs, hs, rp, hp);
        chk(rp == 1 && hp == 1 && rs == 0, "R9 stop one pulse", rp * 10 + hp, 11);
        scl_in = 1'b0;
        watch(8, rs, hs, rp, hp);
        sda_in = 1'b0;
        watch(8, rs, hs, rp, hp);
        chk(hs == 0 && hp == 0, "R10 sda fall with scl low", hs + hp, 0);
        sda_in = 1'b1;
        watch(8, rs, hs, rp, hp);
        chk(hs == 0 && hp == 0, "R10 sda rise with scl low", hs + hp, 0);
        scl_in = 1'b1;
        watch(8, rs, hs, rp, hp);
        chk(hs == 0 && hp == 0, "R10 scl rise only", hs + hp, 0);

        // Slow strobe (N=3)
        set_cfg(4, 3);
        watch(10, rs, hs, rp, hp);
        sda_in = 1'b0;
        watch(40, rs, hs, rp, hp);
        chk(rs == 1 && hs == 1, "R8 start at slow strobe", rs * 10 + hs, 11);
        sda_in = 1'b1;
        watch(40, rs, hs, rp, hp);
        chk(rp == 1 && hp == 1, "R9 stop at slow strobe", rp * 10 + hp, 11);

        // R7: no flags while disabled
        @(negedge clk);
        enable = 1'b0;
        sda_in = 1'b0;
        watch(10, rs, hs, rp, hp);
        sda_in = 1'b1;
        watch(10, rs, hs, rp, hp);
        chk(hs == 0 && hp == 0, "R7 no flags when disabled", hs + hp, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule